// File: doc/BRIEF.md
# Interrupt-IN Transmit Endpoint Buffer

This block holds the outgoing data for one interrupt-IN endpoint whose packets carry at most eight bytes. Firmware pushes bytes through a data-port strobe. A packet becomes ready to send ("armed") in one of two ways. Loading the eighth byte arms it with no further action. Pulsing the short-packet command arms whatever smaller amount has been loaded, and with nothing loaded it arms an empty packet. If the short-packet command arrives after a full eight-byte load, the block also queues one zero-length packet. That packet is served on the host request that follows the full one.

A single-cycle host request strobe asks for the armed packet. The block then streams the bytes in write order on a simple valid/acknowledge byte interface and marks the final byte. A zero-length packet is reported as a one-cycle indication. When nothing is armed, the block gives a one-cycle not-ready indication and sends no data. Each finished packet sets a sticky completion flag, which firmware clears by writing 1, and raises a one-cycle interrupt so that firmware can refill the buffer. Firmware may also preload data before the first host request.

Top module: `intin_txbuf`

## Requirements
- R1: After reset, fill is 0, armed is 0, pkt_done is 0, and tx_valid, tx_zlp, host_nak and ep_irq are all 0.
- R2: Each accepted data-port write stores its byte and raises fill by one. The write that brings fill to 8 sets armed at the same clock edge, with no command needed.
- R3: A short-packet pulse with fewer than 8 bytes loaded sets armed and leaves fill unchanged. With 0 bytes loaded, it arms a zero-length packet.
- R4: A short-packet pulse while a full 8-byte packet is armed queues one zero-length packet. The next host request after the 8-byte packet completes returns tx_zlp and not a refusal.
- R5: A host request while a data packet is armed sets tx_valid from the next cycle. tx_byte presents the bytes in write order, each tx_ack moves to the next byte, and tx_last is high only on the final byte.
- R6: On the edge that samples tx_ack for the final byte, or the edge that samples a request served with a zero-length packet, pkt_done becomes 1 and ep_irq is high for that cycle. At that point fill becomes 0 and armed becomes 0.
- R7: A pkt_done_clr pulse clears pkt_done. If a completion happens in the same cycle, pkt_done stays 1.
- R8: A host request with nothing armed and no zero-length packet queued gives host_nak high for the next cycle only. In that cycle tx_valid and tx_zlp stay 0.
- R9: Data-port writes are ignored while armed is 1 or a zero-length packet is queued: fill and the stored bytes do not change.
- R10: A host request during a transfer is ignored, with no change to tx_byte and no host_nak. A short-packet pulse while a partial packet is armed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_wr | input | 1 | Data-port write strobe |
| fw_data | input | 8 | Byte for the data port |
| fw_short | input | 1 | Short-packet command pulse |
| pkt_done_clr | input | 1 | Write-1 clear of the completion flag |
| host_in | input | 1 | Host IN request strobe |
| tx_ack | input | 1 | Transmit side accepted the current byte |
| tx_valid | output | 1 | A data byte is on tx_byte |
| tx_byte | output | 8 | Current byte of the packet |
| tx_last | output | 1 | Current byte is the last of the packet |
| tx_zlp | output | 1 | One-cycle zero-length packet served |
| host_nak | output | 1 | One-cycle not-ready reply |
| fill | output | 4 | Bytes currently loaded |
| armed | output | 1 | A packet is armed or being sent |
| pkt_done | output | 1 | Sticky packet-complete flag |
| ep_irq | output | 1 | One-cycle endpoint interrupt |

## Verification
Writes, arming and the short command all show in fill and armed at the edge that samples them. tx_valid follows one edge after the host request. host_nak, tx_zlp, pkt_done and ep_irq appear at the edge that samples the request or the final tx_ack. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each result is checked in the cycle it is due. Each single-cycle pulse is checked once more a cycle later to confirm that it has dropped.

// File: rtl/intin_txbuf.sv
module intin_txbuf #(
  parameter int MAXPKT = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(MAXPKT + 1),
  localparam int AW = $clog2(MAXPKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fw_wr,
  input  logic [DW-1:0] fw_data,
  input  logic          fw_short,
  input  logic          pkt_done_clr,
  input  logic          host_in,
  input  logic          tx_ack,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          tx_last,
  output logic          tx_zlp,
  output logic          host_nak,
  output logic [CW-1:0] fill,
  output logic          armed,
  output logic          pkt_done,
  output logic          ep_irq
);

  typedef enum logic [1:0] {S_LOAD, S_ARMED, S_SEND} st_t;

  st_t           state_q;
  logic [DW-1:0] mem [MAXPKT];
  logic [CW-1:0] fill_q, rd_q;
  logic          zlp_q, done_q, irq_q, zlpo_q, nak_q;

  wire full_q     = fill_q == CW'(MAXPKT);
  wire can_wr     = fw_wr && state_q == S_LOAD && !zlp_q;
  wire fills      = can_wr && fill_q == CW'(MAXPKT - 1);
  wire last_beat  = state_q == S_SEND && rd_q == fill_q - 1'b1;
  wire beat_done  = last_beat && tx_ack;
  wire serve_data = host_in && state_q == S_ARMED && fill_q != '0;
  wire serve_zlp  = host_in && ((state_q == S_ARMED && fill_q == '0) ||
                                (state_q == S_LOAD && zlp_q));
  wire refuse     = host_in && state_q == S_LOAD && !zlp_q;
  wire complete   = beat_done || serve_zlp;
  wire queue_zlp  = fw_short && !zlp_q && ((state_q != S_LOAD && full_q) || fills);
  wire arm_short  = fw_short && state_q == S_LOAD && !zlp_q && !fills;

  always_ff @(posedge clk) begin
    if (can_wr) mem[fill_q[AW-1:0]] <= fw_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_LOAD;
      fill_q  <= '0;
      rd_q    <= '0;
      zlp_q   <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      zlpo_q  <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      case (state_q)
        S_LOAD:  if (fills || arm_short) state_q <= S_ARMED;
        S_ARMED: if (serve_data) state_q <= S_SEND;
                 else if (serve_zlp) state_q <= S_LOAD;
        S_SEND:  if (beat_done) state_q <= S_LOAD;
        default: state_q <= S_LOAD;
      endcase

      if (can_wr) fill_q <= fill_q + 1'b1;
      else if (beat_done) fill_q <= '0;

      if (serve_data) rd_q <= '0;
      else if (state_q == S_SEND && tx_ack) rd_q <= rd_q + 1'b1;

      if (queue_zlp) zlp_q <= 1'b1;
      else if (serve_zlp && state_q == S_LOAD) zlp_q <= 1'b0;

      if (complete) done_q <= 1'b1;
      else if (pkt_done_clr) done_q <= 1'b0;

      irq_q  <= complete;
      zlpo_q <= serve_zlp;
      nak_q  <= refuse;
    end
  end

  assign tx_valid = state_q == S_SEND;
  assign tx_byte  = mem[rd_q[AW-1:0]];
  assign tx_last  = last_beat;
  assign tx_zlp   = zlpo_q;
  assign host_nak = nak_q;
  assign fill     = fill_q;
  assign armed    = state_q != S_LOAD;
  assign pkt_done = done_q;
  assign ep_irq   = irq_q;

endmodule

// File: rtl/intin_txbuf_chk.sv
module intin_txbuf_chk #(
  parameter int MAXPKT = 8,
  localparam int CW = $clog2(MAXPKT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fw_wr,
  input logic          host_in,
  input logic          tx_ack,
  input logic          tx_valid,
  input logic          tx_zlp,
  input logic          host_nak,
  input logic [CW-1:0] fill,
  input logic          armed,
  input logic          pkt_done,
  input logic          ep_irq
);

  // R2
  full_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill == CW'(MAXPKT) |-> armed);

  // R5
  valid_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> armed);

  // R6
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> pkt_done && !tx_valid);

  // R8
  nak_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_nak |-> !tx_valid && !tx_zlp);

  // R9
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && fw_wr && !(tx_valid && tx_ack) |=> $stable(fill));

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(MAXPKT));

  // R10
  busy_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && host_in |=> !host_nak);

endmodule

bind intin_txbuf intin_txbuf_chk #(.MAXPKT(MAXPKT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fw_wr(fw_wr), .host_in(host_in), .tx_ack(tx_ack),
  .tx_valid(tx_valid), .tx_zlp(tx_zlp), .host_nak(host_nak), .fill(fill),
  .armed(armed), .pkt_done(pkt_done), .ep_irq(ep_irq)
);

// File: tb/intin_txbuf_bench.sv
module intin_txbuf_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fw_wr = 0, fw_short = 0, pkt_done_clr = 0, host_in = 0, tx_ack = 0;
  logic [7:0] fw_data = '0;
  logic tx_valid, tx_last, tx_zlp, host_nak, armed, pkt_done, ep_irq;
  logic [7:0] tx_byte;
  logic [3:0] fill;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intin_txbuf u_intin_txbuf (
    .clk(clk), .rst_n(rst_n), .fw_wr(fw_wr), .fw_data(fw_data), .fw_short(fw_short),
    .pkt_done_clr(pkt_done_clr), .host_in(host_in), .tx_ack(tx_ack),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_zlp(tx_zlp),
    .host_nak(host_nak), .fill(fill), .armed(armed), .pkt_done(pkt_done), .ep_irq(ep_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); fw_wr = 1; fw_data = b;
    @(negedge clk); fw_wr = 0;
  endtask

  task automatic short_cmd();
    @(negedge clk); fw_short = 1;
    @(negedge clk); fw_short = 0;
  endtask

  task automatic clr_done();
    @(negedge clk); pkt_done_clr = 1;
    @(negedge clk); pkt_done_clr = 0;
  endtask

  task automatic request();
    @(negedge clk); host_in = 1;
    @(negedge clk); host_in = 0;
  endtask

  task automatic receive(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      check("R5 valid", tx_valid, 1);
      check("R5 byte", tx_byte, base + 8'(i));
      check("R5 last", tx_last, (i == n - 1));
      tx_ack = 1;
      @(negedge clk);
    end
    tx_ack = 0;
    check("R6 done", pkt_done, 1);
    check("R6 irq", ep_irq, 1);
    check("R6 fill", fill, 0);
    check("R6 armed", armed, 0);
    check("R6 valid off", tx_valid, 0);
    @(negedge clk);
    check("R6 irq pulse", ep_irq, 0);
  endtask

  task automatic t_reset();
    check("R1 fill", fill, 0);
    check("R1 armed", armed, 0);
    check("R1 done", pkt_done, 0);
    check("R1 outputs", {tx_valid, tx_zlp, host_nak, ep_irq}, 0);
  endtask

  task automatic t_refuse();
    request();
    check("R8 nak", host_nak, 1);
    check("R8 no data", {tx_valid, tx_zlp}, 0);
    @(negedge clk);
    check("R8 nak pulse", host_nak, 0);
  endtask

  task automatic t_short_packet();
    wr_byte(8'h10); wr_byte(8'h11); wr_byte(8'h12);
    check("R2 fill", fill, 3);
    check("R2 not armed", armed, 0);
    short_cmd();
    check("R3 armed", armed, 1);
    check("R3 fill", fill, 3);
    wr_byte(8'hEE);
    check("R9 fill held", fill, 3);
    short_cmd();
    check("R10 short ignored", {armed, fill}, {1'b1, 4'd3});
    request();
    check("R5 valid", tx_valid, 1);
    request();
    check("R10 no nak", host_nak, 0);
    check("R10 byte held", tx_byte, 8'h10);
    receive(3, 8'h10);
    clr_done();
    check("R7 cleared", pkt_done, 0);
  endtask

  task automatic t_full_packet();
    for (int i = 0; i < 7; i++) wr_byte(8'h20 + 8'(i));
    check("R2 seven", {armed, fill}, {1'b0, 4'd7});
    wr_byte(8'h27);
    check("R2 auto arm", {armed, fill}, {1'b1, 4'd8});
    request();
    receive(8, 8'h20);
    t_refuse();
    clr_done();
  endtask

  task automatic t_full_then_zlp();
    for (int i = 0; i < 8; i++) wr_byte(8'h40 + 8'(i));
    short_cmd();
    request();
    receive(8, 8'h40);
    clr_done();
    wr_byte(8'h99);
    check("R9 zlp blocks writes", fill, 0);
    @(negedge clk); host_in = 1; pkt_done_clr = 1;
    @(negedge clk); host_in = 0; pkt_done_clr = 0;
    check("R4 zlp", tx_zlp, 1);
    check("R4 no nak", host_nak, 0);
    check("R4 no data", tx_valid, 0);
    check("R6 zlp irq", ep_irq, 1);
    check("R7 set wins", pkt_done, 1);
    @(negedge clk);
    check("R4 zlp pulse", tx_zlp, 0);
    clr_done();
    t_refuse();
  endtask

  task automatic t_empty_short();
    short_cmd();
    check("R3 empty armed", {armed, fill}, {1'b1, 4'd0});
    request();
    check("R3 zlp", tx_zlp, 1);
    check("R3 no data", tx_valid, 0);
    check("R6 irq", ep_irq, 1);
    check("R6 disarmed", armed, 0);
    clr_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_refuse();
    t_short_packet();
    t_full_packet();
    t_full_then_zlp();
    t_empty_short();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule